// File: doc/BRIEF.md
# Graphic LCD Column Driver Host Port

This block is the microcontroller side of a 64-column graphic LCD column driver. A host reaches it over an 8-bit parallel bus. Three select lines, a read/write line, a data-or-command line and an enable strobe qualify each access. A write is taken when the strobe falls. Read data is presented while the strobe is high. Each access goes either to a 512-byte display memory or to a small command path. The command path sets the display enable flag, the first displayed line, and the page and column pointers.

The memory is arranged as 8 pages of 64 columns, one byte per column, and a 1 bit is a lit pixel. The host pointer is a page plus a column. The column advances by one, wrapping from 63 to 0, after every memory access. A second, independent read port lets the scan logic fetch any byte at any time. The bus logic runs on one system clock. It passes the strobe through a synchroniser and acts on the falling edge it detects, so a strobe must stay high and low for a few clocks.

The bus is split into an input, an output and an output enable, so the tri-state buffer sits at the pad.

Top module: `lcd_host_port`

## Requirements
- R1: While `rst_n` is low, `disp_on` is cleared to 0 and `start_line` to 0, and the page and column pointers and the read buffer are cleared to 0. Afterwards these change only through bus accesses.
- R2: `bus_oe` is 1 only when all of these hold: `cs1_n`=0, `cs2_n`=0, `cs3`=1, `rd_wr`=1 (read), and the synchronised strobe is high. Otherwise it is 0.
- R3: A selected write with `dc_sel`=1 stores `bus_in` at the current page and column when the strobe falls. The scan port then returns that byte for that page and column.
- R4: Every selected memory read or write advances the column by one. Column 63 wraps to 0, and the page stays unchanged.
- R5: A selected memory read (`dc_sel`=1, `rd_wr`=1) drives `bus_out` with the read buffer while the strobe is high. At the falling edge, the byte at the current pointer is loaded into the buffer. The first read after a pointer change therefore returns stale data.
- R6: The command byte 0x3F sets `disp_on` to 1, and 0x3E clears it to 0 (pattern 0011111b).
- R7: A command byte 11sssssb sets `start_line` to sssss s (bits 5..0).
- R8: A command byte 10111pppb sets the page to ppp. A command byte 01ccccccb sets the column to cccccc.
- R9: A strobe taken while any select line is inactive writes nothing, moves no pointer and changes no register.
- R10: A selected read with `dc_sel`=0 drives a status byte. Bit 5 is 1 when the display is off. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs1_n | input | 1 | Select line one, active low |
| cs2_n | input | 1 | Select line two, active low |
| cs3 | input | 1 | Select line three, active high |
| strobe | input | 1 | Enable strobe: write at its fall, read while high |
| rd_wr | input | 1 | 1 = read, 0 = write |
| dc_sel | input | 1 | 1 = display memory data, 0 = command/status |
| bus_in | input | 8 | Data bus from the host |
| bus_out | output | 8 | Data bus towards the host |
| bus_oe | output | 1 | Output enable for the pad buffer |
| scan_page | input | 3 | Scan port page |
| scan_col | input | 6 | Scan port column |
| scan_byte | output | 8 | Byte at the scan address |
| disp_on | output | 1 | Display enable flag |
| start_line | output | 6 | First displayed line |

## Verification
The bench targets four corner cases. The first is the one-access read latency. A design that returned the fresh byte would show the target data on the dummy read and lose one byte of a burst. The second is column wrap at 63. An incrementer that carried into the page, or that saturated, would put the byte after column 63 on the wrong page or overwrite column 63. The third is a strobe with one select line inactive. A design that ignored the select would store the byte or advance the pointer, and the next legitimate write would land one column late. The fourth is output enable gating during writes and deselected reads, and a second reset after activity, which must clear the display flag and the start line.

// File: rtl/lcd_port_pkg.sv
package lcd_port_pkg;
    localparam int DATA_W   = 8;
    localparam int NUM_COLS = 64;
    localparam int NUM_PAGES = 8;
    localparam int COL_W    = $clog2(NUM_COLS);
    localparam int PAGE_W   = $clog2(NUM_PAGES);
    localparam int ADDR_W   = COL_W + PAGE_W;
    localparam int MEM_DEPTH = NUM_COLS * NUM_PAGES;
    localparam int STATUS_OFF_BIT = 5;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_DISP,
        CMD_START,
        CMD_PAGE,
        CMD_COL
    } cmd_e;

    typedef struct packed {
        logic               on;
        logic [COL_W-1:0]   start;
        logic [PAGE_W-1:0]  page;
        logic [COL_W-1:0]   col;
        logic [DATA_W-1:0]  rbuf;
        logic               l_sel;
        logic               l_dc;
        logic               l_rd;
        logic [DATA_W-1:0]  l_data;
    } port_state_t;
endpackage

// File: rtl/lcd_strobe_sync.sv
module lcd_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic level,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;
    logic              prev_q;
    logic              prev_d;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = raw;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], raw};
        end
    endgenerate

    always_comb prev_d = chain_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign level = chain_q[STAGES-1];
    assign fall  = prev_q & ~chain_q[STAGES-1];

    // a detected fall lasts exactly one cycle (supports R3 write timing)
    assert_fall_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/lcd_cmd_decode.sv
module lcd_cmd_decode
    import lcd_port_pkg::*;
(
    input  logic [DATA_W-1:0] code,
    output cmd_e              cmd,
    output logic [COL_W-1:0]  arg
);
    always_comb begin
        cmd = CMD_NONE;
        arg = code[COL_W-1:0];
        if (code[7:1] == 7'b0011111) begin
            cmd = CMD_DISP;
        end else if (code[7:6] == 2'b11) begin
            cmd = CMD_START;
        end else if (code[7:3] == 5'b10111) begin
            cmd = CMD_PAGE;
        end else if (code[7:6] == 2'b01) begin
            cmd = CMD_COL;
        end
    end
endmodule

// File: rtl/lcd_disp_mem.sv
module lcd_disp_mem #(
    parameter int DW    = 8,
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata_a = cells[raddr_a];
    assign rdata_b = cells[raddr_b];

    assert_store_R3: assert property (@(posedge clk)
        we |=> (cells[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/lcd_host_port.sv
module lcd_host_port
    import lcd_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs1_n,
    input  logic              cs2_n,
    input  logic              cs3,
    input  logic              strobe,
    input  logic              rd_wr,
    input  logic              dc_sel,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    input  logic [PAGE_W-1:0] scan_page,
    input  logic [COL_W-1:0]  scan_col,
    output logic [DATA_W-1:0] scan_byte,
    output logic              disp_on,
    output logic [COL_W-1:0]  start_line
);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(NUM_COLS - 1);

    port_state_t st_q, st_d;

    logic              stb_lvl, stb_fall;
    logic              sel_live;
    cmd_e              cmd;
    logic [COL_W-1:0]  cmd_arg;
    logic              mem_we;
    logic [ADDR_W-1:0] host_addr;
    logic [DATA_W-1:0] host_rdata;
    logic              data_act, rd_act;
    logic [DATA_W-1:0] status_byte;

    lcd_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (strobe),
        .level (stb_lvl),
        .fall  (stb_fall)
    );

    lcd_cmd_decode u_dec (
        .code (st_q.l_data),
        .cmd  (cmd),
        .arg  (cmd_arg)
    );

    assign host_addr = {st_q.page, st_q.col};

    lcd_disp_mem #(.DW(DATA_W), .DEPTH(MEM_DEPTH)) u_mem (
        .clk     (clk),
        .we      (mem_we),
        .waddr   (host_addr),
        .wdata   (st_q.l_data),
        .raddr_a (host_addr),
        .rdata_a (host_rdata),
        .raddr_b ({scan_page, scan_col}),
        .rdata_b (scan_byte)
    );

    assign sel_live = ~cs1_n & ~cs2_n & cs3;

    always_comb begin
        st_d     = st_q;
        data_act = stb_fall & st_q.l_sel & st_q.l_dc;
        rd_act   = data_act & st_q.l_rd;
        mem_we   = data_act & ~st_q.l_rd;

        if (stb_lvl) begin
            st_d.l_sel  = sel_live;
            st_d.l_dc   = dc_sel;
            st_d.l_rd   = rd_wr;
            st_d.l_data = bus_in;
        end

        if (data_act) begin
            st_d.col = st_q.col + 1'b1;
            if (st_q.l_rd) st_d.rbuf = host_rdata;
        end

        if (stb_fall && st_q.l_sel && !st_q.l_dc && !st_q.l_rd) begin
            unique case (cmd)
                CMD_DISP:  st_d.on    = cmd_arg[0];
                CMD_START: st_d.start = cmd_arg;
                CMD_PAGE:  st_d.page  = cmd_arg[PAGE_W-1:0];
                CMD_COL:   st_d.col   = cmd_arg;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status_byte = '0;
        status_byte[STATUS_OFF_BIT] = ~st_q.on;
    end

    assign bus_oe     = sel_live & rd_wr & stb_lvl;
    assign bus_out    = dc_sel ? st_q.rbuf : status_byte;
    assign disp_on    = st_q.on;
    assign start_line = st_q.start;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (st_q.on == 1'b0 && st_q.start == '0));

    assert_col_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_act && st_q.col == COL_LAST) |=> (st_q.col == '0 && $stable(st_q.page)));

    assert_rbuf_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_act |=> $stable(st_q.rbuf));

    assert_on_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_fall |=> ($stable(st_q.on) && $stable(st_q.start)));

    assert_desel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_fall && !st_q.l_sel) |=> ($stable(st_q.col) && $stable(st_q.page)
                                       && $stable(st_q.on) && $stable(st_q.rbuf)));
endmodule

// File: tb/sim_lcd_host_port.sv
module sim_lcd_host_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs1_n = 1'b1, cs2_n = 1'b1, cs3 = 1'b0;
    logic       strobe = 1'b0, rd_wr = 1'b0, dc_sel = 1'b0;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out;
    logic       bus_oe;
    logic [2:0] scan_page = 3'd0;
    logic [5:0] scan_col = 6'd0;
    logic [7:0] scan_byte;
    logic       disp_on;
    logic [5:0] start_line;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    lcd_host_port u0 (
        .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2_n(cs2_n), .cs3(cs3),
        .strobe(strobe), .rd_wr(rd_wr), .dc_sel(dc_sel), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .scan_page(scan_page),
        .scan_col(scan_col), .scan_byte(scan_byte), .disp_on(disp_on),
        .start_line(start_line)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic select(input bit on);
        cs1_n = ~on; cs2_n = ~on; cs3 = on;
    endtask

    task automatic bus_write(input bit dc, input logic [7:0] val, input bit sel);
        @(negedge clk);
        select(sel); rd_wr = 1'b0; dc_sel = dc; bus_in = val;
        strobe = 1'b1;
        repeat (4) @(negedge clk);
        strobe = 1'b0;
        repeat (6) @(negedge clk);
        select(1'b0);
    endtask

    task automatic bus_read(input bit dc, input bit sel, output logic [7:0] val, output logic oe);
        @(negedge clk);
        select(sel); rd_wr = 1'b1; dc_sel = dc;
        strobe = 1'b1;
        repeat (4) @(negedge clk);
        val = bus_out; oe = bus_oe;
        strobe = 1'b0;
        repeat (6) @(negedge clk);
        select(1'b0); rd_wr = 1'b0;
    endtask

    function automatic logic [7:0] scan(input logic [2:0] p, input logic [5:0] c);
        scan_page = p; scan_col = c;
        return 8'h00;
    endfunction

    task automatic scan_check(input string req, input logic [2:0] p, input logic [5:0] c, input logic [7:0] exp);
        logic [7:0] unused;
        unused = scan(p, c);
        #1;
        check(req, scan_byte, exp);
    endtask

    task automatic t_reset();
        check("R1 disp_on", {7'd0, disp_on}, 8'h00);
        check("R1 start_line", {2'd0, start_line}, 8'h00);
        check("R1 bus_oe", {7'd0, bus_oe}, 8'h00);
    endtask

    task automatic t_commands();
        logic [7:0] v; logic oe;
        bus_write(1'b0, 8'h3F, 1'b1);
        check("R6 display on", {7'd0, disp_on}, 8'h01);
        bus_read(1'b0, 1'b1, v, oe);
        check("R10 status on", v, 8'h00);
        check("R2 oe on selected read", {7'd0, oe}, 8'h01);
        bus_write(1'b0, 8'h3E, 1'b1);
        check("R6 display off", {7'd0, disp_on}, 8'h00);
        bus_read(1'b0, 1'b1, v, oe);
        check("R10 status off", v, 8'h20);
        bus_write(1'b0, 8'hC5, 1'b1);
        check("R7 start line", {2'd0, start_line}, 8'h05);
        bus_write(1'b0, 8'hFF, 1'b1);
        check("R7 start line max", {2'd0, start_line}, 8'h3F);
    endtask

    task automatic t_write();
        bus_write(1'b0, 8'hBA, 1'b1);
        bus_write(1'b0, 8'h4A, 1'b1);
        bus_write(1'b1, 8'hA5, 1'b1);
        bus_write(1'b1, 8'h5A, 1'b1);
        scan_check("R3 R8 store p2 c10", 3'd2, 6'd10, 8'hA5);
        scan_check("R3 R4 store p2 c11", 3'd2, 6'd11, 8'h5A);
    endtask

    task automatic t_read();
        logic [7:0] v; logic oe;
        bus_write(1'b0, 8'hBA, 1'b1);
        bus_write(1'b0, 8'h4A, 1'b1);
        bus_read(1'b1, 1'b1, v, oe);
        check("R5 dummy read stale", v, 8'h00);
        bus_read(1'b1, 1'b1, v, oe);
        check("R5 first real read", v, 8'hA5);
        bus_read(1'b1, 1'b1, v, oe);
        check("R5 R4 second read", v, 8'h5A);
    endtask

    task automatic t_wrap();
        bus_write(1'b0, 8'hBB, 1'b1);
        bus_write(1'b0, 8'h7F, 1'b1);
        bus_write(1'b1, 8'h11, 1'b1);
        bus_write(1'b1, 8'h22, 1'b1);
        scan_check("R4 last column", 3'd3, 6'd63, 8'h11);
        scan_check("R4 wrap same page", 3'd3, 6'd0, 8'h22);
    endtask

    task automatic t_deselect();
        logic [7:0] v; logic oe;
        bus_write(1'b0, 8'hBD, 1'b1);
        bus_write(1'b0, 8'h40, 1'b1);
        bus_write(1'b1, 8'h00, 1'b1);
        bus_write(1'b0, 8'h40, 1'b1);
        @(negedge clk); cs3 = 1'b0;
        bus_write(1'b1, 8'h77, 1'b0);
        scan_check("R9 deselected write ignored", 3'd5, 6'd0, 8'h00);
        bus_write(1'b0, 8'h3F, 1'b0);
        check("R9 deselected command ignored", {7'd0, disp_on}, 8'h00);
        bus_write(1'b1, 8'h88, 1'b1);
        scan_check("R9 pointer not advanced", 3'd5, 6'd0, 8'h88);
        bus_read(1'b1, 1'b0, v, oe);
        check("R2 oe low when deselected", {7'd0, oe}, 8'h00);
        @(negedge clk);
        select(1'b1); rd_wr = 1'b0; strobe = 1'b1;
        repeat (4) @(negedge clk);
        check("R2 oe low during write", {7'd0, bus_oe}, 8'h00);
        select(1'b0); strobe = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset_again();
        bus_write(1'b0, 8'h3F, 1'b1);
        bus_write(1'b0, 8'hC9, 1'b1);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 reset clears on", {7'd0, disp_on}, 8'h00);
        check("R1 reset clears start", {2'd0, start_line}, 8'h00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_commands();
        t_write();
        t_read();
        t_wrap();
        t_deselect();
        t_reset_again();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule